// File: doc/BRIEF.md
# Phase-Table Port Scheduler

This block decides which ingress port may send next into one egress virtual channel. A schedule of 32 phases is held in a small table. Each phase carries a 4-bit port identifier. A pointer walks the phases in ascending order. From the pointer, the block grants the first phase whose port is implemented and has a request pending. Phases that do not qualify are passed over within the same cycle. When no phase from the pointer up to the last one qualifies, the pointer returns to phase 0. That return costs one idle cycle and is called a wrap.

The table and a scheme selector are written with 32-bit configuration writes. A write lands in a staging copy. The staging copy becomes the active copy only when the pointer wraps, so a pass through the schedule that is under way always finishes under the rules it started with. Two schemes exist:
- Round-robin: phase n serves port n mod 16, and the table is ignored.
- Table-driven: each phase serves the port stored for it.

A parameter bit vector advertises which schemes may be selected. The set of implemented ports is a parameter mask.

The grant is a registered valid, port and phase. It is held until the requester pulses accept.

Top module: `port_phase_arbiter`

## Requirements
- R1: After a synchronous reset, `gnt_valid` is 0, the pointer is at phase 0, the active scheme is round-robin (0), and both table copies hold port (n mod 16) in phase n.
- R2: Table entries use configuration addresses 0 to 3. Phase n is in the word at address n/8, at bits [4*(n mod 8)+3 : 4*(n mod 8)]. In table-driven mode the port granted for a phase is the identifier stored there.
- R3: While no grant is held, the next clock edge grants the lowest phase at or above the pointer whose port is set in `PORT_MASK` and has its `req` bit high. Phases with an unimplemented identifier or with no request are skipped without extra cycles, and the pointer moves to the granted phase.
- R4: A grant keeps its port and phase stable until `accept` is sampled high. The edge that samples `accept` removes the grant and sets the pointer to the granted phase plus one.
- R5: If no phase from the pointer through 31 qualifies, the pointer returns to 0 and no grant is issued in that cycle. An accept of phase 31 also returns the pointer to 0. Both events are wraps.
- R6: Configuration writes change only the staging copy. The active table and the active scheme take the staging values at a wrap, and at no other time.
- R7: Address 4 bits [1:0] select the scheme: 0 is round-robin (phase n serves port n mod 16) and 1 is table-driven. A write whose value is not set in `SCHEME_CAP` is ignored. `scheme` shows the active scheme.
- R8: At most one grant is outstanding, and a granted port is always set in `PORT_MASK`. Writes to addresses 5 to 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 16 | Request per port identifier |
| accept | input | 1 | Requester takes the held grant |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| gnt_valid | output | 1 | Grant outstanding |
| gnt_port | output | 4 | Granted port identifier |
| gnt_phase | output | 5 | Phase that produced the grant |
| scheme | output | 2 | Active scheme |

## Verification
The embedded properties check the following on every cycle:
- a held grant stays stable until accepted, and drops right after the accept;
- a new grant never lies below the phase the pointer held;
- every wrap lands the pointer on 0;
- the active copies stay frozen outside a wrap;
- the active scheme is always an advertised one.

Only the bench scenarios can show the rest:
- the choice of the exact lowest qualifying phase;
- the nibble packing;
- a staged schedule taking over at the right wrap;
- an unadvertised select being dropped.

The behavioural model covers these on every cycle of a directed and a random run.

// File: rtl/ppa_pkg.sv
package ppa_pkg;
  localparam int ID_W   = 4;
  localparam int NIDS   = 1 << ID_W;
  localparam int CFG_DW = 32;
  localparam int SCH_W  = 2;

  typedef logic [ID_W-1:0] port_id_t;

  typedef enum logic [SCH_W-1:0] {
    SCH_RR    = 2'd0,
    SCH_TABLE = 2'd1,
    SCH_RSV2  = 2'd2,
    SCH_RSV3  = 2'd3
  } scheme_e;
endpackage

// File: rtl/ppa_table.sv
module ppa_table
  import ppa_pkg::*;
#(
  parameter int               NUM_PHASES = 32,
  parameter logic [(1<<SCH_W)-1:0] SCHEME_CAP = 4'b0011,
  localparam int PER_WORD = CFG_DW / ID_W,
  localparam int NWORDS   = NUM_PHASES / PER_WORD,
  localparam int AW       = $clog2(NWORDS + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [AW-1:0]              wr_addr,
  input  logic [CFG_DW-1:0]          wr_data,
  input  logic                       commit,
  output logic [NUM_PHASES*ID_W-1:0] act_flat,
  output scheme_e                    scheme_act
);
  scheme_e sch_stg_q;
  scheme_e sch_act_q;
  logic    sch_wr_ok;

  function automatic logic [CFG_DW-1:0] rr_word(int w);
    logic [CFG_DW-1:0] v;
    v = '0;
    for (int k = 0; k < PER_WORD; k++)
      v[k*ID_W +: ID_W] = port_id_t'((w*PER_WORD + k) % NIDS);
    return v;
  endfunction

  generate
    for (genvar w = 0; w < NWORDS; w++) begin : g_word
      logic [CFG_DW-1:0] stg_q;
      logic [CFG_DW-1:0] act_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          stg_q <= rr_word(w);
          act_q <= rr_word(w);
        end else begin
          if (commit)
            act_q <= stg_q;
          if (wr_en && wr_addr == AW'(w))
            stg_q <= wr_data;
        end
      end
      assign act_flat[w*CFG_DW +: CFG_DW] = act_q;
    end
  endgenerate

  assign sch_wr_ok = wr_en && (wr_addr == AW'(NWORDS)) && SCHEME_CAP[wr_data[SCH_W-1:0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      sch_stg_q <= SCH_RR;
      sch_act_q <= SCH_RR;
    end else begin
      if (commit)
        sch_act_q <= sch_stg_q;
      if (sch_wr_ok)
        sch_stg_q <= scheme_e'(wr_data[SCH_W-1:0]);
    end
  end

  assign scheme_act = sch_act_q;

  // R7: only advertised schemes ever become active
  assert_scheme_advertised_R7: assert property (@(posedge clk) disable iff (rst)
    SCHEME_CAP[sch_act_q]);

  // R6: active copies move only at a wrap
  assert_active_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(act_flat) && $stable(sch_act_q));
endmodule

// File: rtl/ppa_search.sv
module ppa_search
  import ppa_pkg::*;
#(
  parameter int               NUM_PHASES = 32,
  parameter logic [NIDS-1:0]  PORT_MASK  = 16'h00FF,
  localparam int PW = $clog2(NUM_PHASES)
) (
  input  logic [PW-1:0]              ptr,
  input  logic [NUM_PHASES*ID_W-1:0] entries,
  input  logic [NIDS-1:0]            req,
  output logic                       hit,
  output logic [PW-1:0]              hit_phase,
  output port_id_t                   hit_port
);
  always_comb begin
    hit       = 1'b0;
    hit_phase = '0;
    hit_port  = '0;
    for (int i = NUM_PHASES - 1; i >= 0; i--) begin
      if (PW'(i) >= ptr && PORT_MASK[entries[i*ID_W +: ID_W]]
          && req[entries[i*ID_W +: ID_W]]) begin
        hit       = 1'b1;
        hit_phase = PW'(i);
        hit_port  = entries[i*ID_W +: ID_W];
      end
    end
  end
endmodule

// File: rtl/port_phase_arbiter.sv
module port_phase_arbiter
  import ppa_pkg::*;
#(
  parameter int                    NUM_PHASES = 32,
  parameter logic [NIDS-1:0]       PORT_MASK  = 16'h00FF,
  parameter logic [(1<<SCH_W)-1:0] SCHEME_CAP = 4'b0011,
  localparam int PW       = $clog2(NUM_PHASES),
  localparam int PER_WORD = CFG_DW / ID_W,
  localparam int NWORDS   = NUM_PHASES / PER_WORD,
  localparam int AW       = $clog2(NWORDS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NIDS-1:0]   req,
  input  logic              accept,
  input  logic              cfg_wr,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic              gnt_valid,
  output logic [ID_W-1:0]   gnt_port,
  output logic [PW-1:0]     gnt_phase,
  output logic [SCH_W-1:0]  scheme
);
  localparam logic [PW-1:0] LAST = PW'(NUM_PHASES - 1);

  logic [NUM_PHASES*ID_W-1:0] act_flat;
  logic [NUM_PHASES*ID_W-1:0] eff_flat;
  scheme_e                    sch_act;
  logic [PW-1:0]              ptr_q;
  logic                       gv_q;
  port_id_t                   gp_q;
  logic [PW-1:0]              gph_q;
  logic                       hit;
  logic [PW-1:0]              hit_phase;
  port_id_t                   hit_port;
  logic                       commit;

  ppa_table #(.NUM_PHASES(NUM_PHASES), .SCHEME_CAP(SCHEME_CAP)) u_table (
    .clk(clk), .rst(rst), .wr_en(cfg_wr), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
    .commit(commit), .act_flat(act_flat), .scheme_act(sch_act)
  );

  generate
    for (genvar g = 0; g < NUM_PHASES; g++) begin : g_phase
      localparam port_id_t RR_ID = port_id_t'(g % NIDS);
      assign eff_flat[g*ID_W +: ID_W] =
        (sch_act == SCH_TABLE) ? act_flat[g*ID_W +: ID_W] : RR_ID;
    end
  endgenerate

  ppa_search #(.NUM_PHASES(NUM_PHASES), .PORT_MASK(PORT_MASK)) u_search (
    .ptr(ptr_q), .entries(eff_flat), .req(req),
    .hit(hit), .hit_phase(hit_phase), .hit_port(hit_port)
  );

  assign commit = gv_q ? (accept && gph_q == LAST) : !hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      gv_q  <= 1'b0;
      gp_q  <= '0;
      gph_q <= '0;
    end else if (gv_q) begin
      if (accept) begin
        gv_q  <= 1'b0;
        ptr_q <= (gph_q == LAST) ? '0 : gph_q + PW'(1);
      end
    end else if (hit) begin
      gv_q  <= 1'b1;
      gp_q  <= hit_port;
      gph_q <= hit_phase;
      ptr_q <= hit_phase;
    end else begin
      ptr_q <= '0;
    end
  end

  assign gnt_valid = gv_q;
  assign gnt_port  = gp_q;
  assign gnt_phase = gph_q;
  assign scheme    = sch_act;

  assert_port_implemented_R8: assert property (@(posedge clk) disable iff (rst)
    gnt_valid |-> PORT_MASK[gnt_port]);

  assert_hold_until_accept_R4: assert property (@(posedge clk) disable iff (rst)
    gnt_valid && !accept |=> gnt_valid && $stable(gnt_port) && $stable(gnt_phase));

  assert_release_on_accept_R4: assert property (@(posedge clk) disable iff (rst)
    gnt_valid && accept |=> !gnt_valid);

  assert_forward_search_R3: assert property (@(posedge clk) disable iff (rst)
    !gnt_valid |=> !gnt_valid || gnt_phase >= $past(ptr_q));

  assert_wrap_to_zero_R5: assert property (@(posedge clk) disable iff (rst)
    commit |=> ptr_q == '0);
endmodule

// File: tb/tb_port_phase_arbiter.sv
module tb_port_phase_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] MASK = 16'h00FF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] req = '0;
  logic        accept = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        gnt_valid;
  logic [3:0]  gnt_port;
  logic [4:0]  gnt_phase;
  logic [1:0]  scheme;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  port_phase_arbiter #(.PORT_MASK(MASK)) dut (
    .clk(clk), .rst(rst), .req(req), .accept(accept), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .gnt_valid(gnt_valid),
    .gnt_port(gnt_port), .gnt_phase(gnt_phase), .scheme(scheme)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural model
  int m_ptr, m_gp, m_gph, m_sch, m_sch_stg;
  bit m_gv;
  int m_act[32];
  int m_stg[32];

  function automatic int ent(int p);
    return (m_sch == 1) ? m_act[p] : p % 16;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ptr = 0; m_gv = 0; m_gp = 0; m_gph = 0; m_sch = 0; m_sch_stg = 0;
      for (int n = 0; n < 32; n++) begin m_act[n] = n % 16; m_stg[n] = n % 16; end
    end else begin
      bit wrap;
      int found;
      wrap = 0;
      if (m_gv) begin
        if (accept) begin
          m_gv = 0;
          if (m_gph == 31) begin m_ptr = 0; wrap = 1; end
          else m_ptr = m_gph + 1;
        end
      end else begin
        found = -1;
        for (int p = m_ptr; p < 32; p++)
          if (found < 0 && MASK[ent(p)] && req[ent(p)]) found = p;
        if (found >= 0) begin
          m_gv = 1; m_gph = found; m_gp = ent(found); m_ptr = found;
        end else begin
          m_ptr = 0; wrap = 1;
        end
      end
      if (wrap) begin
        for (int n = 0; n < 32; n++) m_act[n] = m_stg[n];
        m_sch = m_sch_stg;
      end
      if (cfg_wr) begin
        if (cfg_addr < 4)
          for (int k = 0; k < 8; k++) m_stg[cfg_addr*8 + k] = (cfg_wdata >> (4*k)) & 15;
        else if (cfg_addr == 4 && cfg_wdata[1:0] < 2)
          m_sch_stg = cfg_wdata[1:0];
      end
    end
  end

  task automatic chk(string r, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", r, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R3 grant valid", gnt_valid, m_gv);
      if (gnt_valid && m_gv) begin
        chk("R3 grant phase", gnt_phase, m_gph);
        chk("R2 grant port", gnt_port, m_gp);
        chk("R8 port implemented", MASK[gnt_port], 1);
      end
      chk("R7 active scheme", scheme, m_sch);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, logic [31:0] d);
    cfg_wr = 1; cfg_addr = 3'(a); cfg_wdata = d;
    step(1);
    cfg_wr = 0;
  endtask

  initial begin
    step(3);
    chk("R1 reset valid", gnt_valid, 0);
    chk("R1 reset scheme", scheme, 0);
    rst = 0;
    // R3: round-robin, single requester at port 5
    req = 16'h1 << 5;
    step(1);
    chk("R3 first grant", gnt_valid, 1);
    chk("R3 port", gnt_port, 5);
    chk("R3 phase", gnt_phase, 5);
    step(2);
    chk("R4 held port", gnt_port, 5);
    chk("R4 held valid", gnt_valid, 1);
    accept = 1;
    step(1);
    chk("R4 released", gnt_valid, 0);
    accept = 0; req = 16'h1 << 2;
    step(1);
    chk("R3 phase after ptr", gnt_phase, 18);
    accept = 1;
    step(1);
    step(1);
    chk("R5 wrap cycle idle", gnt_valid, 0);
    step(1);
    chk("R5 after wrap phase", gnt_phase, 2);
    step(1);
    // R6: stage table and scheme while a grant is held
    accept = 0; req = 16'h1 << 5;
    step(1);
    for (int w = 0; w < 4; w++) wr(w, 32'h44444444);
    wr(4, 32'h1);
    chk("R6 scheme staged only", scheme, 0);
    chk("R6 grant undisturbed", gnt_port, 5);
    req = 0; accept = 1;
    step(1);
    accept = 0;
    chk("R6 no wrap yet", scheme, 0);
    step(1);
    chk("R6 active after wrap", scheme, 1);
    req = 16'h1 << 1;
    step(3);
    chk("R6 new table in use", gnt_valid, 0);
    req = 16'h1 << 4;
    step(1);
    chk("R2 table port", gnt_port, 4);
    chk("R2 table phase", gnt_phase, 0);
    // R3/R8: skip invalid identifiers 9 and 15 in one cycle
    wr(0, 32'h777777F9);
    accept = 1; req = 0;
    step(1);
    accept = 0;
    step(1);
    req = (16'h1 << 7) | (16'h1 << 9);
    step(1);
    chk("R3 skip phase", gnt_phase, 2);
    chk("R8 skip port", gnt_port, 7);
    // R7: unadvertised select is dropped
    wr(4, 32'h3);
    wr(6, 32'h0);
    accept = 1; req = 0;
    step(1);
    accept = 0;
    step(2);
    chk("R7 ignored select", scheme, 1);
    wr(4, 32'h0);
    step(1);
    chk("R7 back to round-robin", scheme, 0);
    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      req = 16'($urandom);
      accept = ($urandom % 3) != 0;
      if ($urandom % 16 == 0) begin
        cfg_wr = 1; cfg_addr = 3'($urandom % 8);
        cfg_wdata = (cfg_addr == 4) ? ($urandom % 4) : $urandom;
      end else cfg_wr = 0;
      step(1);
    end
    cfg_wr = 0;
    step(2);
    finish_run();
  end
endmodule